// File: doc/BRIEF.md
# Timecode Card Status Word Formatter

This block produces the four 32-bit status words that a timecode option card returns to a host. It also contains the host-side checker that confirms the card is fitted. On the formatting side, the block takes four kinds of input:

- the running time of day (hours, minutes, seconds, frames) as plain binary counts;
- the frame-rate code and the drop-frame flag;
- the video standard flags, the two input-valid flags and the lock flag;
- a 14-bit phase count from the clock recovery loop.

It clamps each time field to its legal range, converts it to BCD with a 3-bit tens digit and a 4-bit units digit, and packs everything into words. In these words, the top bit of every byte is forced to one. A one-cycle capture strobe loads all four words together, so a reader never sees a mixture of old and new fields.

On the checking side, a small state machine accepts four words offered one after another with a valid flag. It checks the marker pattern, rebuilds the phase count from the two 7-bit halves in the third word, and raises a one-cycle done pulse carrying the presence verdict. The checker has these named states:

- `CK_W0`, `CK_W1`, `CK_W2`, `CK_W3`: waiting for each word in turn.
- `CK_REPORT`: the single result cycle.

The checker has these named transitions:

- `take` (CK_Wn to the next state on a valid word, ending at CK_REPORT after word 3);
- `wait` (hold in the same CK_Wn state while valid is low);
- `rearm` (CK_REPORT back to CK_W0 unconditionally).

A word offered during CK_REPORT is discarded.

Top module: `tc_status_fmt`

## Requirements
- R1: Once captured, words 0, 1 and 2 have bits 31, 23, 15 and 7 set to one. Word 3 is exactly 0x80008000.
- R2: Word 0 carries hours in bits 30-24, minutes in bits 22-16, seconds in bits 14-8 and frames in bits 6-0. Each field is BCD, with the tens digit in its upper 3 bits and the units digit in its lower 4 bits.
- R3: Hours above 23 are encoded as 23, and minutes or seconds above 59 are encoded as 59.
- R4: The frame count is clamped to one less than the frame rate chosen by the format code: 23 for code 0 (24 fps), 24 for code 1 (25 fps), and 29 for code 2 (29.97 fps) and code 3 (30 fps). Counts within range pass unchanged.
- R5: Word 1 carries the format code in bits 11-10, drop-frame in bit 9, PAL in bit 6, NTSC in bit 5, word-clock-valid in bit 4, LTC-valid in bit 3 and lock in bit 0. All other non-marker bits are zero.
- R6: Word 2 carries phase bits 13-7 in bits 14-8 and phase bits 6-0 in bits 6-0. All other non-marker bits are zero.
- R7: All four status words are zero after reset. They change only on the clock edge at which the capture strobe is high, and take the inputs sampled at that edge.
- R8: The checker takes one word per clock while its valid input is high, in order word 0 to word 3, and waits while valid is low. Done is high for exactly the one cycle after the edge that took word 3.
- R9: Present, valid with done, is one only when bits 31, 23, 15 and 7 of words 0-2 are all one, bits 31 and 15 of word 3 are one, and bits 14-0 of word 3 are zero.
- R10: The phase output, valid with done, equals bits 6-0 of word 2 plus bits 14-8 of word 2 shifted left by 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_i | input | 1 | One-cycle strobe that loads all four status words |
| hours_i | input | 5 | Hours count, binary |
| minutes_i | input | 6 | Minutes count, binary |
| seconds_i | input | 6 | Seconds count, binary |
| frames_i | input | 5 | Frame count, binary |
| rate_code_i | input | 2 | Frame-rate code: 0=24, 1=25, 2=29.97, 3=30 fps |
| drop_frame_i | input | 1 | Drop-frame counting active |
| pal_i | input | 1 | PAL video input detected |
| ntsc_i | input | 1 | NTSC video input detected |
| wclk_ok_i | input | 1 | Word clock input valid |
| ltc_ok_i | input | 1 | LTC input valid |
| lock_i | input | 1 | Card locked |
| phase_i | input | 14 | Phase count from clock recovery |
| stat_w0_o | output | 32 | Status word 0 (time of day) |
| stat_w1_o | output | 32 | Status word 1 (format and flags) |
| stat_w2_o | output | 32 | Status word 2 (phase halves) |
| stat_w3_o | output | 32 | Status word 3 (signature) |
| chk_valid_i | input | 1 | Checker word valid |
| chk_word_i | input | 32 | Checker word, offered in order 0 to 3 |
| chk_done_o | output | 1 | One-cycle result pulse |
| chk_present_o | output | 1 | Presence verdict, valid with done |
| chk_phase_o | output | 14 | Rebuilt phase, valid with done |

## Verification
The bench builds the block with its default widths: 5-bit hours and frames, 6-bit minutes and seconds, and a 14-bit phase. These widths let every over-range input reach the clamp, namely hours up to 31, minutes and seconds up to 63, and frames up to 31 under each of the four format codes. With this phase width, the all-ones, single-bit and mixed phase values all pass through both 7-bit halves. The captured words are looped back into the checker with and without idle cycles between them. Single marker bits are then corrupted, and stray low bits are set in word 3, to drive the verdict to zero.

// File: rtl/tc_stat_pkg.sv
package tc_stat_pkg;

    typedef enum logic [2:0] {
        CK_W0,
        CK_W1,
        CK_W2,
        CK_W3,
        CK_REPORT
    } chk_state_e;

    localparam logic [31:0] MARK_MASK  = 32'h8080_8080;
    localparam logic [31:0] SIGN_WORD3 = 32'h8000_8000;
    localparam int unsigned FIELD_W    = 7;

    // value below 80 -> {3-bit tens, 4-bit units}
    function automatic logic [6:0] to_bcd7(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] u;
        t = v / 7'd10;
        u = v % 7'd10;
        return {t[2:0], u[3:0]};
    endfunction

    function automatic logic [6:0] frame_limit(input logic [1:0] code);
        logic [6:0] r;
        unique case (code)
            2'd0:    r = 7'd23;
            2'd1:    r = 7'd24;
            default: r = 7'd29;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tc_field_bcd.sv
module tc_field_bcd
    import tc_stat_pkg::*;
#(
    parameter int unsigned IN_W = 6
) (
    input  logic [IN_W-1:0] val_i,
    input  logic [6:0]      limit_i,
    output logic [6:0]      bcd_o
);
    localparam int unsigned CW = (IN_W > 7) ? IN_W : 7;

    logic [CW-1:0] val_w;
    logic [CW-1:0] lim_w;
    logic [CW-1:0] clamped;

    always_comb begin
        val_w   = CW'(val_i);
        lim_w   = CW'(limit_i);
        clamped = (val_w > lim_w) ? lim_w : val_w;
        bcd_o   = to_bcd7(clamped[6:0]);
    end
endmodule

// File: rtl/tc_word_pack.sv
module tc_word_pack
    import tc_stat_pkg::*;
#(
    parameter int unsigned HOUR_W  = 5,
    parameter int unsigned MIN_W   = 6,
    parameter int unsigned FRAME_W = 5,
    parameter int unsigned PHASE_W = 14
) (
    input  logic [HOUR_W-1:0]  hours_i,
    input  logic [MIN_W-1:0]   minutes_i,
    input  logic [MIN_W-1:0]   seconds_i,
    input  logic [FRAME_W-1:0] frames_i,
    input  logic [1:0]         rate_code_i,
    input  logic               drop_frame_i,
    input  logic               pal_i,
    input  logic               ntsc_i,
    input  logic               wclk_ok_i,
    input  logic               ltc_ok_i,
    input  logic               lock_i,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [31:0]        w0_o,
    output logic [31:0]        w1_o,
    output logic [31:0]        w2_o,
    output logic [31:0]        w3_o
);
    localparam int unsigned HALF = PHASE_W / 2;

    logic [6:0] h_bcd, m_bcd, s_bcd, f_bcd;
    logic [6:0] ph_hi, ph_lo;

    tc_field_bcd #(.IN_W(HOUR_W))  u_hours (.val_i(hours_i),   .limit_i(7'd23), .bcd_o(h_bcd));
    tc_field_bcd #(.IN_W(MIN_W))   u_mins  (.val_i(minutes_i), .limit_i(7'd59), .bcd_o(m_bcd));
    tc_field_bcd #(.IN_W(MIN_W))   u_secs  (.val_i(seconds_i), .limit_i(7'd59), .bcd_o(s_bcd));
    tc_field_bcd #(.IN_W(FRAME_W)) u_frms  (.val_i(frames_i),
                                            .limit_i(frame_limit(rate_code_i)),
                                            .bcd_o(f_bcd));

    always_comb begin
        ph_lo = 7'(phase_i[HALF-1:0]);
        ph_hi = 7'(phase_i[PHASE_W-1:HALF]);
        w0_o  = {1'b1, h_bcd, 1'b1, m_bcd, 1'b1, s_bcd, 1'b1, f_bcd};
        w1_o  = {1'b1, 7'd0, 1'b1, 7'd0,
                 1'b1, 3'd0, rate_code_i, drop_frame_i, 1'b0,
                 1'b1, pal_i, ntsc_i, wclk_ok_i, ltc_ok_i, 2'b00, lock_i};
        w2_o  = {1'b1, 7'd0, 1'b1, 7'd0, 1'b1, ph_hi, 1'b1, ph_lo};
        w3_o  = SIGN_WORD3;
    end
endmodule

// File: rtl/tc_presence_fsm.sv
module tc_presence_fsm
    import tc_stat_pkg::*;
#(
    parameter int unsigned PHASE_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_valid_i,
    input  logic [31:0]        word_i,
    output logic               done_o,
    output logic               present_o,
    output logic [PHASE_W-1:0] phase_o
);
    chk_state_e state_q, state_d;
    logic       ok_q;
    logic       present_q;
    logic [PHASE_W-1:0] phase_q;
    logic       marks_ok;
    logic       tail_ok;
    logic [PHASE_W-1:0] phase_rebuilt;

    always_comb begin
        marks_ok      = word_i[31] & word_i[23] & word_i[15] & word_i[7];
        tail_ok       = word_i[31] & word_i[15] & (word_i[14:0] == 15'd0);
        phase_rebuilt = PHASE_W'(word_i[6:0]) + (PHASE_W'(word_i[14:8]) << 7);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CK_W0;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_W0:     if (word_valid_i) state_d = CK_W1;
            CK_W1:     if (word_valid_i) state_d = CK_W2;
            CK_W2:     if (word_valid_i) state_d = CK_W3;
            CK_W3:     if (word_valid_i) state_d = CK_REPORT;
            CK_REPORT: state_d = CK_W0;
            default:   state_d = CK_W0;
        endcase
    end

    // output and verdict registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q      <= 1'b0;
            present_q <= 1'b0;
            phase_q   <= '0;
        end else if (word_valid_i) begin
            unique case (state_q)
                CK_W0: ok_q <= marks_ok;
                CK_W1: ok_q <= ok_q & marks_ok;
                CK_W2: begin
                    ok_q    <= ok_q & marks_ok;
                    phase_q <= phase_rebuilt;
                end
                CK_W3:     present_q <= ok_q & tail_ok;
                CK_REPORT: ;
                default:   ;
            endcase
        end
    end

    assign done_o    = (state_q == CK_REPORT);
    assign present_o = present_q;
    assign phase_o   = phase_q;
endmodule

// File: rtl/tc_status_fmt.sv
module tc_status_fmt
    import tc_stat_pkg::*;
#(
    parameter int unsigned HOUR_W  = 5,
    parameter int unsigned MIN_W   = 6,
    parameter int unsigned FRAME_W = 5,
    parameter int unsigned PHASE_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic [HOUR_W-1:0]  hours_i,
    input  logic [MIN_W-1:0]   minutes_i,
    input  logic [MIN_W-1:0]   seconds_i,
    input  logic [FRAME_W-1:0] frames_i,
    input  logic [1:0]         rate_code_i,
    input  logic               drop_frame_i,
    input  logic               pal_i,
    input  logic               ntsc_i,
    input  logic               wclk_ok_i,
    input  logic               ltc_ok_i,
    input  logic               lock_i,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [31:0]        stat_w0_o,
    output logic [31:0]        stat_w1_o,
    output logic [31:0]        stat_w2_o,
    output logic [31:0]        stat_w3_o,
    input  logic               chk_valid_i,
    input  logic [31:0]        chk_word_i,
    output logic               chk_done_o,
    output logic               chk_present_o,
    output logic [PHASE_W-1:0] chk_phase_o
);
    logic [31:0] nx_w0, nx_w1, nx_w2, nx_w3;

    tc_word_pack #(
        .HOUR_W(HOUR_W), .MIN_W(MIN_W), .FRAME_W(FRAME_W), .PHASE_W(PHASE_W)
    ) u_pack (
        .hours_i(hours_i), .minutes_i(minutes_i), .seconds_i(seconds_i),
        .frames_i(frames_i), .rate_code_i(rate_code_i),
        .drop_frame_i(drop_frame_i), .pal_i(pal_i), .ntsc_i(ntsc_i),
        .wclk_ok_i(wclk_ok_i), .ltc_ok_i(ltc_ok_i), .lock_i(lock_i),
        .phase_i(phase_i),
        .w0_o(nx_w0), .w1_o(nx_w1), .w2_o(nx_w2), .w3_o(nx_w3)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_w0_o <= '0;
            stat_w1_o <= '0;
            stat_w2_o <= '0;
            stat_w3_o <= '0;
        end else if (capture_i) begin
            stat_w0_o <= nx_w0;
            stat_w1_o <= nx_w1;
            stat_w2_o <= nx_w2;
            stat_w3_o <= nx_w3;
        end
    end

    tc_presence_fsm #(.PHASE_W(PHASE_W)) u_chk_fsm (
        .clk(clk), .rst_n(rst_n),
        .word_valid_i(chk_valid_i), .word_i(chk_word_i),
        .done_o(chk_done_o), .present_o(chk_present_o), .phase_o(chk_phase_o)
    );
endmodule

// File: rtl/tc_status_fmt_chk.sv
module tc_status_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        capture_i,
    input logic [31:0] stat_w0_o,
    input logic [31:0] stat_w1_o,
    input logic [31:0] stat_w2_o,
    input logic [31:0] stat_w3_o,
    input logic        chk_done_o,
    input logic        chk_present_o
);
    logic cap_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            cap_q  <= capture_i;
            if (capture_i) seen_q <= 1'b1;
        end
    end

    p_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((stat_w0_o & 32'h8080_8080) == 32'h8080_8080) &&
                   ((stat_w1_o & 32'h8080_8080) == 32'h8080_8080) &&
                   ((stat_w2_o & 32'h8080_8080) == 32'h8080_8080) &&
                   (stat_w3_o == 32'h8000_8000));

    p_hours_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stat_w0_o[30:28] <= 3'd2) && (stat_w0_o[27:24] <= 4'd9) &&
                   !((stat_w0_o[30:28] == 3'd2) && (stat_w0_o[27:24] > 4'd3)));

    p_minsec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stat_w0_o[22:20] <= 3'd5) && (stat_w0_o[19:16] <= 4'd9) &&
                   (stat_w0_o[14:12] <= 3'd5) && (stat_w0_o[11:8] <= 4'd9));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q |-> $stable(stat_w0_o) && $stable(stat_w1_o) &&
                   $stable(stat_w2_o) && $stable(stat_w3_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done_o |=> !chk_done_o);

    p_present_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_present_o) |-> chk_done_o);
endmodule

bind tc_status_fmt tc_status_fmt_chk u_fmt_chk (
    .clk(clk), .rst_n(rst_n), .capture_i(capture_i),
    .stat_w0_o(stat_w0_o), .stat_w1_o(stat_w1_o),
    .stat_w2_o(stat_w2_o), .stat_w3_o(stat_w3_o),
    .chk_done_o(chk_done_o), .chk_present_o(chk_present_o)
);

// File: tb/tc_status_fmt_tb.sv
module tc_status_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_i = 1'b0;
    logic [4:0]  hours_i = '0;
    logic [5:0]  minutes_i = '0;
    logic [5:0]  seconds_i = '0;
    logic [4:0]  frames_i = '0;
    logic [1:0]  rate_code_i = '0;
    logic        drop_frame_i = 1'b0, pal_i = 1'b0, ntsc_i = 1'b0;
    logic        wclk_ok_i = 1'b0, ltc_ok_i = 1'b0, lock_i = 1'b0;
    logic [13:0] phase_i = '0;
    logic [31:0] stat_w0_o, stat_w1_o, stat_w2_o, stat_w3_o;
    logic        chk_valid_i = 1'b0;
    logic [31:0] chk_word_i = '0;
    logic        chk_done_o, chk_present_o;
    logic [13:0] chk_phase_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tc_status_fmt u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] bcd(input int v);
        return 7'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [31:0] exp_w0(input int h, input int m, input int s, input int f);
        return {1'b1, bcd(h), 1'b1, bcd(m), 1'b1, bcd(s), 1'b1, bcd(f)};
    endfunction

    function automatic logic [31:0] exp_w1();
        return {16'h8080, 1'b1, 3'd0, rate_code_i, drop_frame_i, 1'b0,
                1'b1, pal_i, ntsc_i, wclk_ok_i, ltc_ok_i, 2'b00, lock_i};
    endfunction

    task automatic capture();
        @(negedge clk) capture_i = 1'b1;
        @(negedge clk) capture_i = 1'b0;
    endtask

    task automatic set_time(input int h, input int m, input int s, input int f, input int code);
        hours_i = 5'(h); minutes_i = 6'(m); seconds_i = 6'(s);
        frames_i = 5'(f); rate_code_i = 2'(code);
    endtask

    // offer four words, optional idle cycle after each; ends at the negedge after word 3 is taken
    task automatic send4(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d, input bit gaps);
        logic [31:0] w [4];
        w[0] = a; w[1] = b; w[2] = c; w[3] = d;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) begin chk_valid_i = 1'b1; chk_word_i = w[i]; end
            if (gaps && i < 3) begin
                @(negedge clk) chk_valid_i = 1'b0;
            end
        end
        @(negedge clk) chk_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R7 reset w0", stat_w0_o, 32'h0);
        check("R7 reset w3", stat_w3_o, 32'h0);
        check("R8 reset done", 32'(chk_done_o), 32'h0);
        check("R9 reset present", 32'(chk_present_o), 32'h0);
    endtask

    task automatic t_pack();
        set_time(13, 47, 5, 22, 1);
        capture();
        check("R2 w0 fields", stat_w0_o, exp_w0(13, 47, 5, 22));
        check("R1 w3 signature", stat_w3_o, 32'h8000_8000);
        set_time(0, 0, 0, 0, 0);
        capture();
        check("R2 w0 zero time", stat_w0_o, exp_w0(0, 0, 0, 0));
        check("R1 w0 markers", stat_w0_o, 32'h8080_8080);
    endtask

    task automatic t_clamp();
        set_time(31, 63, 60, 5, 3);
        capture();
        check("R3 clamp high", stat_w0_o, exp_w0(23, 59, 59, 5));
        set_time(24, 60, 63, 5, 3);
        capture();
        check("R3 clamp edge", stat_w0_o, exp_w0(23, 59, 59, 5));
        set_time(23, 59, 59, 5, 3);
        capture();
        check("R3 legal max", stat_w0_o, exp_w0(23, 59, 59, 5));
    endtask

    task automatic t_frames();
        int lim [4] = '{23, 24, 29, 29};
        for (int c = 0; c < 4; c++) begin
            set_time(1, 2, 3, 31, c);
            capture();
            check("R4 frame clamp", stat_w0_o, exp_w0(1, 2, 3, lim[c]));
        end
        set_time(1, 2, 3, 24, 0);
        capture();
        check("R4 frames 24 at 24fps", stat_w0_o, exp_w0(1, 2, 3, 23));
        set_time(1, 2, 3, 24, 1);
        capture();
        check("R4 frames 24 at 25fps", stat_w0_o, exp_w0(1, 2, 3, 24));
    endtask

    task automatic t_flags();
        rate_code_i = 2'd2; drop_frame_i = 1; pal_i = 0; ntsc_i = 1;
        wclk_ok_i = 0; ltc_ok_i = 1; lock_i = 1;
        capture();
        check("R5 flags a", stat_w1_o, exp_w1());
        rate_code_i = 2'd1; drop_frame_i = 0; pal_i = 1; ntsc_i = 0;
        wclk_ok_i = 1; ltc_ok_i = 0; lock_i = 0;
        capture();
        check("R5 flags b", stat_w1_o, exp_w1());
        check("R5 flags b literal", stat_w1_o, 32'h8080_84D0);
    endtask

    task automatic t_phase();
        phase_i = 14'h3FFF;
        capture();
        check("R6 phase ones", stat_w2_o, 32'h8080_FFFF);
        phase_i = 14'h0080;
        capture();
        check("R6 phase bit7", stat_w2_o, 32'h8080_8180);
        phase_i = 14'h2A55;
        capture();
        check("R6 phase mixed", stat_w2_o, {16'h8080, 1'b1, 7'h54, 1'b1, 7'h55});
    endtask

    task automatic t_hold();
        logic [31:0] a, b, c;
        a = stat_w0_o; b = stat_w1_o; c = stat_w2_o;
        set_time(9, 9, 9, 9, 0);
        lock_i = ~lock_i; phase_i = 14'h0123;
        repeat (3) @(negedge clk);
        check("R7 hold w0", stat_w0_o, a);
        check("R7 hold w1", stat_w1_o, b);
        check("R7 hold w2", stat_w2_o, c);
    endtask

    task automatic t_present_ok(input bit gaps);
        phase_i = 14'h1ABC;
        capture();
        send4(stat_w0_o, stat_w1_o, stat_w2_o, stat_w3_o, gaps);
        check(gaps ? "R8 done with gaps" : "R8 done", 32'(chk_done_o), 32'h1);
        check("R9 present ok", 32'(chk_present_o), 32'h1);
        check("R10 phase rebuilt", 32'(chk_phase_o), 32'h1ABC);
        @(negedge clk);
        check("R8 done one cycle", 32'(chk_done_o), 32'h0);
    endtask

    task automatic t_present_bad();
        send4(stat_w0_o, stat_w1_o & ~32'h0080_0000, stat_w2_o, stat_w3_o, 0);
        check("R8 done bad marker", 32'(chk_done_o), 32'h1);
        check("R9 missing marker", 32'(chk_present_o), 32'h0);
        @(negedge clk);
        send4(stat_w0_o, stat_w1_o, stat_w2_o, stat_w3_o | 32'h8, 0);
        check("R9 word3 low bit", 32'(chk_present_o), 32'h0);
        @(negedge clk);
        send4(32'h8080_8080, 32'h8080_8080, {16'h8080, 1'b1, 7'h01, 1'b1, 7'h02},
              32'hFFFF_8000, 1);
        check("R9 word3 upper ignored", 32'(chk_present_o), 32'h1);
        check("R10 phase small", 32'(chk_phase_o), 32'h0082);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pack();
        t_clamp();
        t_frames();
        t_flags();
        t_phase();
        t_hold();
        t_present_ok(0);
        t_present_ok(1);
        t_present_bad();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule